// File: doc/BRIEF.md
# Dual-Clock FIFO with Safety-Margin Flow Control

This block carries data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. Words are held in a small register array. Each side advances its own binary pointer and publishes a registered Gray-coded copy of it. The opposite domain samples that copy through a two-flop synchronizer, decodes it back to binary and subtracts it from its own pointer. The result is a numeric fill level.

Flow control is deliberately conservative. The producer is told to stop while a configurable number of free slots still remains. The consumer is told to stop while the same number of stored words still remains. Because of this, the stale pointer copies seen across the crossing can never cause an overrun or an underrun. As a consequence, up to MARGIN words stay parked inside the FIFO until more data arrives. Read data is presented ahead of the read strobe: the word at the head is on the output whenever read-valid is high.

Top module: `margin_fifo`

## Requirements
- R1: After both domain resets are released, wready is 1 and rvalid is 0, and the FIFO behaves as empty; words written before the reset are gone.
- R2: Every word accepted (wen high while wready is high at a wclk rising edge) appears on rdata exactly once, in acceptance order, and is consumed when ren is high while rvalid is high at an rclk rising edge.
- R3: With DEPTH = 2^ADDR_W slots, wready is 0 whenever the writer's fill view leaves MARGIN or fewer free slots. The FIFO therefore never holds more than DEPTH - MARGIN words (14 with the defaults).
- R4: rvalid is 0 whenever the reader's fill view is MARGIN or fewer words. Once both pointers have settled, rvalid equals (fill > MARGIN) and wready equals (DEPTH - fill > MARGIN).
- R5: A write strobe while wready is 0 is ignored: no word is stored and the write pointer does not move.
- R6: A read strobe while rvalid is 0 is ignored: the read pointer does not move and no word is lost.
- R7: When the opposite side moves data, the flags recover: wready returns to 1 after reads free space, and rvalid returns to 1 after writes add data.
- R8: Pointers are ADDR_W+1 bits wide and wrap modulo 2^(ADDR_W+1). Their Gray copies change by at most one bit per clock. Ordering stays correct across many wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-domain asynchronous reset, active low |
| wen | input | 1 | Write strobe |
| wdata | input | DATA_W | Word to store |
| wready | output | 1 | Write accepted this cycle when high |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer-domain asynchronous reset, active low |
| ren | input | 1 | Read strobe (pops the head word) |
| rdata | output | DATA_W | Head word, valid while rvalid is high |
| rvalid | output | 1 | Head word available when high |

## Verification
The FIFO is exercised with write-only bursts, read-only bursts and overlapping bursts, using clocks of 10 ns and 13 ns. A write burst far longer than the room left separates correct throttling at DEPTH - MARGIN from off-by-one or single-slot full logic. A read burst longer than the content checks that the last MARGIN words stay parked and that extra strobes skip nothing. The overlapping bursts carry the pointers through several wraps, so any flaw in the Gray or binary conversion or in the modular subtraction shows up as a wrong or repeated word. A final reset taken with data inside checks that both sides restart empty.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;
  // number of slots for a given address width
  function automatic int unsigned fifo_depth(input int unsigned aw);
    return 32'd1 << aw;
  endfunction

  // a side may proceed only while its level is strictly above the margin
  function automatic bit above_margin(input int unsigned level, input int unsigned margin);
    return level > margin;
  endfunction
endpackage

// File: rtl/mfifo_g2b.sv
module mfifo_g2b #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  assign bin[W-1] = gray[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_bit
    assign bin[i] = bin[i+1] ^ gray[i];
  end
endmodule

// File: rtl/mfifo_sync.sv
module mfifo_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/mfifo_side.sv
// One pointer domain: local binary/Gray pointer, decoded remote pointer,
// fill level and margin gate. IS_WRITER picks the level it gates on.
module mfifo_side #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned MARGIN    = 2,
  parameter bit          IS_WRITER = 1'b1,
  localparam int unsigned PW       = ADDR_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [PW-1:0] far_gray_s,
  output logic          ok,
  output logic          commit,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] gray,
  output logic [PW-1:0] used
);
  localparam int unsigned DEPTH = mfifo_pkg::fifo_depth(ADDR_W);

  logic [PW-1:0] far_bin;
  logic [PW-1:0] ptr_nxt;
  logic [PW-1:0] level;

  mfifo_g2b #(.W(PW)) u_dec (.gray(far_gray_s), .bin(far_bin));

  if (IS_WRITER) begin : g_wr
    assign used  = ptr - far_bin;
    assign level = PW'(DEPTH) - used;
  end else begin : g_rd
    assign used  = far_bin - ptr;
    assign level = used;
  end

  assign ok      = mfifo_pkg::above_margin(32'(level), MARGIN);
  assign commit  = req & ok;
  assign ptr_nxt = ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      gray <= '0;
    end else if (commit) begin
      ptr  <= ptr_nxt;
      gray <= ptr_nxt ^ (ptr_nxt >> 1);
    end
  end
endmodule

// File: rtl/mfifo_store.sv
module mfifo_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = mfifo_pkg::fifo_depth(ADDR_W)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/margin_fifo.sv
module margin_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MARGIN = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  output logic              wready,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] wptr, wgray, wr_used, rgray_w;
  logic [PW-1:0] rptr, rgray, rd_used, wgray_r;
  logic          wr_commit, rd_commit;

  mfifo_side #(.ADDR_W(ADDR_W), .MARGIN(MARGIN), .IS_WRITER(1'b1)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .req(wen), .far_gray_s(rgray_w),
    .ok(wready), .commit(wr_commit), .ptr(wptr), .gray(wgray), .used(wr_used)
  );

  mfifo_side #(.ADDR_W(ADDR_W), .MARGIN(MARGIN), .IS_WRITER(1'b0)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .req(ren), .far_gray_s(wgray_r),
    .ok(rvalid), .commit(rd_commit), .ptr(rptr), .gray(rgray), .used(rd_used)
  );

  mfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
  mfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

  mfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_commit), .waddr(wptr[ADDR_W-1:0]), .wdata(wdata),
    .raddr(rptr[ADDR_W-1:0]), .rdata(rdata)
  );
endmodule

// File: rtl/margin_fifo_chk.sv
module margin_fifo_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MARGIN = 2,
  localparam int unsigned PW    = ADDR_W + 1,
  localparam int unsigned DEPTH = mfifo_pkg::fifo_depth(ADDR_W)
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          wen,
  input logic          wready,
  input logic          wr_commit,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] wr_used,
  input logic          rclk,
  input logic          rrst_n,
  input logic          ren,
  input logic          rvalid,
  input logic          rd_commit,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] rd_used
);
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    32'(wr_used) <= DEPTH - MARGIN);
  assert_rd_view_cap_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    32'(rd_used) <= DEPTH - MARGIN);
  assert_wr_hold_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wen && !wready) |=> $stable(wptr));
  assert_rd_hold_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ren && !rvalid) |=> $stable(rptr));
  assert_wr_step_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_commit |=> wptr == $past(wptr) + 1'b1);
  assert_rd_step_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_commit |=> rptr == $past(rptr) + 1'b1);
  assert_wgray_step_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_rgray_step_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind margin_fifo margin_fifo_chk #(.ADDR_W(ADDR_W), .MARGIN(MARGIN)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .wready(wready), .wr_commit(wr_commit),
  .wptr(wptr), .wgray(wgray), .wr_used(wr_used),
  .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .rvalid(rvalid), .rd_commit(rd_commit),
  .rptr(rptr), .rgray(rgray), .rd_used(rd_used)
);

// File: tb/tb_margin_fifo.sv
module tb_margin_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 13;
  localparam int DEPTH = 16;
  localparam int MARGIN = 2;
  localparam int NROWS = 9;
  // {writes attempted, reads attempted, expected fill afterwards (-1: not fixed)}
  localparam int PLAN [NROWS][3] = '{
    '{5, 0, 5}, '{0, 10, 2}, '{20, 0, 14}, '{0, 4, 10}, '{3, 0, 13},
    '{30, 30, -1}, '{0, 40, 2}, '{40, 0, 14}, '{0, 40, 2}
  };

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0, wen = 0, ren = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic wready, rvalid;

  int total = 0, bad = 0;
  int unsigned seq = 0;
  logic [7:0] q[$];

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2.0) rclk = ~rclk;

  margin_fifo dut (
    .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .wdata(wdata), .wready(wready),
    .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_writes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen = 1;
      wdata = 8'(seq);
      if (wready) begin
        q.push_back(8'(seq));
        seq++;
      end
    end
    @(negedge wclk) wen = 0;
  endtask

  task automatic do_reads(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      ren = 1;
      if (rvalid) begin
        if (q.size() == 0) chk(0, "R6 read with nothing stored", 1, 0);
        else begin
          logic [7:0] e;
          e = q.pop_front();
          chk(rdata == e, "R2 R8 order", rdata, e);
        end
      end
    end
    @(negedge rclk) ren = 0;
  endtask

  task automatic settle_and_flags(input string tag);
    repeat (8) @(negedge rclk);
    @(negedge wclk);
    chk(wready == ((DEPTH - q.size()) > MARGIN), {tag, " R3 R7 wready"}, wready,
        (DEPTH - q.size()) > MARGIN);
    @(negedge rclk);
    chk(rvalid == (q.size() > MARGIN), {tag, " R4 R7 rvalid"}, rvalid, q.size() > MARGIN);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge wclk) wrst_n = 1;
    @(negedge rclk) rrst_n = 1;
    @(negedge wclk);
    chk(wready == 1, "R1 reset wready", wready, 1);
    @(negedge rclk);
    chk(rvalid == 0, "R1 reset rvalid", rvalid, 0);

    for (int r = 0; r < NROWS; r++) begin
      fork
        do_writes(PLAN[r][0]);
        do_reads(PLAN[r][1]);
      join
      settle_and_flags($sformatf("row%0d", r));
      // fill after excess writes / reads shows ignored strobes
      if (PLAN[r][2] >= 0)
        chk(q.size() == PLAN[r][2], "R5 R6 fill level", q.size(), PLAN[r][2]);
    end

    // reset with data inside: both sides restart empty (R1)
    do_writes(6);
    @(negedge wclk);
    wrst_n = 0;
    rrst_n = 0;
    q.delete();
    #(CLK_PERIOD * 2);
    @(negedge wclk) wrst_n = 1;
    @(negedge rclk) rrst_n = 1;
    settle_and_flags("post-reset");
    chk(rvalid == 0, "R1 rvalid after reset", rvalid, 0);
    do_writes(4);
    settle_and_flags("post-reset fill");
    do_reads(3);
    chk(q.size() == MARGIN, "R1 R4 parked words", q.size(), MARGIN);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule